// File: doc/BRIEF.md
# Resistive Sensor Pulse-Width Meter

This block measures two resistive sensor channels, X and Y, by timing a pulse. A resistor sets the length of a pulse from an external one-shot. When a request arrives, the block pulls the chosen channel's active-low trigger line low for a fixed number of clock cycles and then releases it. It then waits for the pulse to appear on one shared pulse input. While the pulse stays high, it counts system-clock cycles.

The count is handed back as the raw sensor value. A longer pulse gives a larger count, because the count grows in a straight line with the resistance. The value depends on the clock rate. Any scaling to angle or ohms happens outside the block.

Requests come in on a valid/ready channel and results leave on a valid/ready channel. Only one measurement runs at a time. `req_ready` is high only when the block is idle. A result stays on the output with all its fields frozen until the consumer raises `res_ready`, so a slow consumer holds off the next request. The pulse input is asynchronous and goes through a synchroniser before it is counted.

Top module: `rpw_meter`

## Requirements
- R1: After reset, `req_ready` is 1, `res_valid` is 0, and both trigger lines are high.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. From that edge until the result handshake, `req_ready` stays 0, and a request held valid meanwhile moves neither trigger line. `res_chan` returns the channel of the request.
- R3: `req_chan` 0 selects X and 1 selects Y. The selected trigger is driven low from the accepting edge for exactly TRIG_CYC consecutive cycles and then released. The other trigger stays high, and the two are never low together.
- R4: Counting starts only after the trigger is released. A pulse high for L clock cycles, with 1 <= L <= MAX_COUNT, gives `res_count` = L and `res_timeout` = 0.
- R5: While `res_valid` is 1 and `res_ready` is 0, `res_valid`, `res_count`, `res_timeout` and `res_chan` hold their values.
- R6: A pulse longer than MAX_COUNT cycles gives `res_count` = MAX_COUNT and `res_timeout` = 1. A pulse of exactly MAX_COUNT cycles is not a timeout.
- R7: If no pulse appears within START_LIMIT cycles after the trigger is released, the result is `res_timeout` = 1 with `res_count` = 0.
- R8: A delay between trigger release and the start of the pulse does not change the count, as long as the delay plus the synchroniser latency stays under START_LIMIT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the counting time base |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Measurement request valid |
| req_ready | output | 1 | Block idle and able to take a request |
| req_chan | input | 1 | Channel select: 0 = X, 1 = Y |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Consumer takes the result |
| res_count | output | CNT_W | Pulse length in clock cycles |
| res_timeout | output | 1 | Pulse saturated or never started |
| res_chan | output | 1 | Channel that was measured |
| trig_x_n | output | 1 | Active-low trigger, channel X |
| trig_y_n | output | 1 | Active-low trigger, channel Y |
| pulse_in | input | 1 | Asynchronous pulse from the one-shot |

## Verification
The assertions check the following on every cycle:
- the two triggers are never low together;
- no trigger stays low longer than TRIG_CYC cycles;
- the block is not ready while it is busy;
- a stalled result holds steady;
- the counter never passes MAX_COUNT;
- a timeout only ever carries the value 0 or MAX_COUNT.

Only the bench's scenarios can show the rest. These are that the count equals the pulse length for every length up to and past the limit on both channels, that the gap before the pulse has no effect, that a missing pulse ends in a timeout, and that the right trigger line was the one pulsed.

// File: rtl/rpw_pkg.sv
package rpw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TRIG,
    ST_WAIT,
    ST_MEAS,
    ST_DONE
  } rpw_state_e;

  typedef enum logic {
    CH_X = 1'b0,
    CH_Y = 1'b1
  } rpw_chan_e;

endpackage

// File: rtl/rpw_sync.sv
module rpw_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES < 2) begin : g_bad
      initial $error("rpw_sync needs at least two stages");
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/rpw_trigger.sv
module rpw_trigger
  import rpw_pkg::*;
#(
  parameter int TRIG_CYC = 8
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start_i,
  input  rpw_chan_e chan_i,
  output logic      trig_x_n_o,
  output logic      trig_y_n_o,
  output logic      last_o
);
  localparam int TW = $clog2(TRIG_CYC + 1);
  localparam logic [TW-1:0] LAST = TW'(TRIG_CYC - 1);

  logic          active_q;
  logic [TW-1:0] cnt_q;
  logic          tx_q, ty_q;

  assign last_o     = active_q && (cnt_q == LAST);
  assign trig_x_n_o = tx_q;
  assign trig_y_n_o = ty_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      tx_q     <= 1'b1;
      ty_q     <= 1'b1;
    end else if (start_i) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
      tx_q     <= (chan_i != CH_X);
      ty_q     <= (chan_i != CH_Y);
    end else if (active_q) begin
      if (last_o) begin
        active_q <= 1'b0;
        cnt_q    <= '0;
        tx_q     <= 1'b1;
        ty_q     <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // Independent run-length monitor for the low phase.
  logic [TW-1:0] low_run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 low_run_q <= '0;
    else if (!tx_q || !ty_q)    low_run_q <= (low_run_q == {TW{1'b1}}) ? low_run_q : low_run_q + 1'b1;
    else                        low_run_q <= '0;
  end

  assert_trig_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_q || !ty_q) |-> (low_run_q < TW'(TRIG_CYC)));

  assert_trig_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |=> (tx_q && ty_q));
endmodule

// File: rtl/rpw_counter.sv
module rpw_counter #(
  parameter int CNT_W     = 16,
  parameter int MAX_COUNT = 60000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             load_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] count_o,
  output logic             at_max_o
);
  localparam logic [CNT_W-1:0] MAXV = CNT_W'(MAX_COUNT);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt_q <= '0;
    else if (clr_i)              cnt_q <= '0;
    else if (load_i)             cnt_q <= CNT_W'(1);
    else if (inc_i && !at_max_o) cnt_q <= cnt_q + 1'b1;
  end

  assign count_o  = cnt_q;
  assign at_max_o = (cnt_q == MAXV);

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= MAXV);

  assert_clr_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == '0));
endmodule

// File: rtl/rpw_meter.sv
module rpw_meter
  import rpw_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int MAX_COUNT   = 60000,
  parameter int TRIG_CYC    = 8,
  parameter int START_LIMIT = 1000,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_chan,
  output logic             res_valid,
  input  logic             res_ready,
  output logic [CNT_W-1:0] res_count,
  output logic             res_timeout,
  output logic             res_chan,
  output logic             trig_x_n,
  output logic             trig_y_n,
  input  logic             pulse_in
);
  localparam int WW = $clog2(START_LIMIT + 1);
  localparam logic [WW-1:0]    WLAST = WW'(START_LIMIT - 1);
  localparam logic [CNT_W-1:0] MAXV  = CNT_W'(MAX_COUNT);

  rpw_state_e    state_q, state_d;
  rpw_chan_e     chan_q;
  logic          tmo_q;
  logic [WW-1:0] wcnt_q;

  logic accept, pulse_hi, trig_last;
  logic c_clr, c_load, c_inc, c_at_max;
  logic [CNT_W-1:0] c_count;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;

  rpw_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  (pulse_in),
    .q_o  (pulse_hi)
  );

  rpw_trigger #(.TRIG_CYC(TRIG_CYC)) u_trig (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (accept),
    .chan_i    (rpw_chan_e'(req_chan)),
    .trig_x_n_o(trig_x_n),
    .trig_y_n_o(trig_y_n),
    .last_o    (trig_last)
  );

  assign c_clr  = accept;
  assign c_load = (state_q == ST_WAIT) && pulse_hi;
  assign c_inc  = (state_q == ST_MEAS) && pulse_hi;

  rpw_counter #(.CNT_W(CNT_W), .MAX_COUNT(MAX_COUNT)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (c_clr),
    .load_i  (c_load),
    .inc_i   (c_inc),
    .count_o (c_count),
    .at_max_o(c_at_max)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (accept)    state_d = ST_TRIG;
      ST_TRIG: if (trig_last) state_d = ST_WAIT;
      ST_WAIT: begin
        if (pulse_hi)             state_d = ST_MEAS;
        else if (wcnt_q == WLAST) state_d = ST_DONE;
      end
      ST_MEAS: begin
        if (!pulse_hi || c_at_max) state_d = ST_DONE;
      end
      ST_DONE: if (res_ready) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      chan_q  <= CH_X;
      tmo_q   <= 1'b0;
      wcnt_q  <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        chan_q <= rpw_chan_e'(req_chan);
        tmo_q  <= 1'b0;
      end
      if (state_q == ST_TRIG) wcnt_q <= '0;
      else if (state_q == ST_WAIT && !pulse_hi && wcnt_q != WLAST) wcnt_q <= wcnt_q + 1'b1;
      if (state_q == ST_WAIT && !pulse_hi && wcnt_q == WLAST) tmo_q <= 1'b1;
      if (state_q == ST_MEAS && pulse_hi && c_at_max)         tmo_q <= 1'b1;
    end
  end

  assign res_valid   = (state_q == ST_DONE);
  assign res_count   = c_count;
  assign res_timeout = tmo_q;
  assign res_chan    = chan_q;

  assert_one_trig_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(!trig_x_n && !trig_y_n));

  assert_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid || !trig_x_n || !trig_y_n) |-> !req_ready);

  assert_res_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_count)
                                   && $stable(res_timeout) && $stable(res_chan)));

  assert_tmo_value_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_timeout) |-> (res_count == MAXV || res_count == '0));

  assert_ok_value_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_timeout) |-> (res_count != '0));
endmodule

// File: tb/sim_rpw_meter.sv
module sim_rpw_meter;
  localparam int CNT_W = 8, MAXC = 20, TRIG = 3, SLIM = 12, SYNC = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_chan = 1'b0, res_ready = 1'b1, pulse_in = 1'b0;
  logic req_ready, res_valid, res_timeout, res_chan, trig_x_n, trig_y_n;
  logic [CNT_W-1:0] res_count;

  always #5 clk = ~clk;

  rpw_meter #(.CNT_W(CNT_W), .MAX_COUNT(MAXC), .TRIG_CYC(TRIG),
              .START_LIMIT(SLIM), .SYNC_STAGES(SYNC)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_chan(req_chan), .res_valid(res_valid), .res_ready(res_ready),
    .res_count(res_count), .res_timeout(res_timeout), .res_chan(res_chan),
    .trig_x_n(trig_x_n), .trig_y_n(trig_y_n), .pulse_in(pulse_in));

  int vectors = 0, fails = 0, cycles = 0;
  bit done = 0;

  // One-shot model and trigger observer, evaluated away from the active edge.
  int pl_len = 0, pl_gap = 0;
  bit pl_en = 0, mdl_busy = 0;
  int gap_left = 0, len_left = 0;
  logic prev_x = 1'b1, prev_y = 1'b1;
  int fall_x = 0, fall_y = 0, run_x = 0, run_y = 0, last_x = 0, last_y = 0;

  always @(negedge clk) begin
    cycles++;
    if (!trig_x_n) run_x++; else if (!prev_x) begin last_x = run_x; run_x = 0; end
    if (!trig_y_n) run_y++; else if (!prev_y) begin last_y = run_y; run_y = 0; end
    if (prev_x && !trig_x_n) fall_x++;
    if (prev_y && !trig_y_n) fall_y++;
    if (pl_en && ((trig_x_n && !prev_x) || (trig_y_n && !prev_y))) begin
      gap_left = pl_gap; len_left = pl_len; mdl_busy = 1;
    end
    if (mdl_busy) begin
      if (gap_left > 0) gap_left--;
      else if (len_left > 0) begin pulse_in = 1'b1; len_left--; end
      else begin pulse_in = 1'b0; mdl_busy = 0; end
    end
    prev_x = trig_x_n; prev_y = trig_y_n;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  task automatic meas(input logic ch, input int len, input int gap, input bit pulse, input string tag);
    int fx0 = fall_x, fy0 = fall_y;
    int exp_cnt, g;
    bit exp_tmo;
    pl_len = len; pl_gap = gap; pl_en = pulse;
    @(negedge clk);
    req_chan = ch; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    g = 0;
    while (!res_valid && g < 500) begin @(negedge clk); g++; end
    if (!pulse)          begin exp_cnt = 0;    exp_tmo = 1; end
    else if (len > MAXC) begin exp_cnt = MAXC; exp_tmo = 1; end
    else                 begin exp_cnt = len;  exp_tmo = 0; end
    chk(res_valid == 1'b1, {tag, " result valid"}, res_valid, 1);
    chk(res_count == CNT_W'(exp_cnt), {tag, " count"}, res_count, exp_cnt);
    chk(res_timeout == exp_tmo, {tag, " timeout"}, res_timeout, exp_tmo);
    chk(res_chan == ch, "R2 result channel", res_chan, ch);
    @(negedge clk);
    while (mdl_busy) @(negedge clk);
    pl_en = 0;
    chk((fall_x - fx0) == (ch == 1'b0 ? 1 : 0), "R3 X trigger falls", fall_x - fx0, ch == 1'b0 ? 1 : 0);
    chk((fall_y - fy0) == (ch == 1'b1 ? 1 : 0), "R3 Y trigger falls", fall_y - fy0, ch == 1'b1 ? 1 : 0);
    chk(((ch == 1'b0) ? last_x : last_y) == TRIG, "R3 trigger low length",
        (ch == 1'b0) ? last_x : last_y, TRIG);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 req_ready", req_ready, 1);
    chk(res_valid == 1'b0, "R1 res_valid", res_valid, 0);
    chk(trig_x_n && trig_y_n, "R1 triggers high", {trig_x_n, trig_y_n}, 3);

    // Sweep every length up to past the limit, both channels, varying gap.
    for (int c = 0; c < 2; c++)
      for (int l = 1; l <= MAXC + 2; l++)
        meas(c[0], l, l % 3, 1'b1,
             (l > MAXC) ? "R6" : ((l % 3 != 0) ? "R8" : "R4"));

    // Exact-limit pulse on both channels.
    meas(1'b0, MAXC, 0, 1'b1, "R6 exact limit");
    meas(1'b1, MAXC, 2, 1'b1, "R6 exact limit");

    // Missing pulse on both channels.
    meas(1'b0, 0, 0, 1'b0, "R7");
    meas(1'b1, 0, 0, 1'b0, "R7");

    // Back-pressure: result held, new request blocked.
    begin
      int fx0, fy0, g;
      res_ready = 1'b0;
      pl_len = 7; pl_gap = 1; pl_en = 1;
      @(negedge clk);
      req_chan = 1'b1; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      g = 0;
      while (!res_valid && g < 500) begin @(negedge clk); g++; end
      while (mdl_busy) @(negedge clk);
      pl_en = 0;
      fx0 = fall_x; fy0 = fall_y;
      req_chan = 1'b0; req_valid = 1'b1;
      for (int k = 0; k < 5; k++) begin
        @(negedge clk);
        chk(res_valid == 1'b1, "R5 valid held", res_valid, 1);
        chk(res_count == CNT_W'(7), "R5 count held", res_count, 7);
        chk(res_chan == 1'b1, "R5 channel held", res_chan, 1);
        chk(req_ready == 1'b0, "R2 busy not ready", req_ready, 0);
      end
      chk((fall_x - fx0) + (fall_y - fy0) == 0, "R2 busy request ignored",
          (fall_x - fx0) + (fall_y - fy0), 0);
      req_valid = 1'b0;
      res_ready = 1'b1;
      @(negedge clk);
      chk(res_valid == 1'b0, "R5 handshake clears", res_valid, 0);
      chk(req_ready == 1'b1, "R2 ready after handshake", req_ready, 1);
    end

    summary();
  end

  initial begin
    wait (cycles > 150000);
    vectors++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
    summary();
  end
endmodule